// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. A host begins a conversion by opening a read access (select and read strobe both high) with the high-byte enable low. The sequencer then clears its trial word and waits for the first conversion-clock tick. From the next tick onward it resolves one bit per tick, most significant first. The trial word drives an external DAC. A single comparator bit returned from outside decides whether each trial bit is kept.

When the last bit has been resolved, the finished word is copied into a result latch and the busy flag drops. The host reads the latch over an 8-bit bus. The high-byte enable selects which part of the word appears on that bus, and the bus is enabled only while an access is open. Any read with the high-byte enable low also starts the next conversion, so the usual flow is to fetch the upper bits first and then the lower byte.

The conversion clock is a tick that a free-running prescaler raises on every `CLK_DIV`-th system clock. Because of this, the time a conversion takes depends on the phase of the start against that tick.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy is low, the trial word is zero, the bus enable is low and the result latch holds zero.
- R2: A conversion starts only on the cycle an access opens (select and read both high where the previous cycle had no access) with the high-byte enable low; busy is high from the next cycle. Holding an access open never starts a second conversion.
- R3: An access that opens with the high-byte enable high does not start a conversion.
- R4: On the first cycle busy is high, the trial word is zero.
- R5: Bits are resolved from bit 11 down to bit 0. Each trial bit is set when its turn comes and is kept when the comparator input is 1 (input at or above the trial word) or cleared when it is 0, so an ideal comparator yields the input code.
- R6: Prescaler ticks fall on every CLK_DIV-th clock edge counted from reset release. The first tick after the start only aligns; the MSB is decided on the second tick and each later bit on the next tick. Busy therefore stays high for 12*CLK_DIV+1 to 13*CLK_DIV cycles, and for exactly 13*CLK_DIV when the start edge is itself a tick edge.
- R7: On the edge that decides bit 0, the finished word is loaded into the result latch and busy falls.
- R8: A start request made while busy is high is ignored, and the result latch keeps its previous value for the whole conversion.
- R9: The bus enable equals select AND read. With the high-byte enable low the bus carries result bits 7..0; with it high, bus bits 3..0 carry result bits 11..8 and bus bits 7..4 are zero.
- R10: A start request is ignored unless at least RD_GAP clock edges without an access have passed since the previous access closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| hi_byte_i | input | 1 | High-byte enable for the read bus |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the trial word |
| trial_o | output | 12 | Trial word to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 8 | Read bus data |
| data_en_o | output | 1 | Three-state enable of the read bus |

## Verification
The hardest cases to reach are both ends of the timing window in R6, because the prescaler phase is not visible at the ports. The bench counts clock edges from reset release and so knows the phase. It inserts zero to CLK_DIV-1 extra cycles before each start, which places starts both on a tick edge and just after one. The bench also drives start requests that must be ignored: during a conversion, after a gap that is too short, and while holding an access open across the end of a conversion. It then checks that busy and the bus contents do not move.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_RUN   = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             load_o,
  output logic [WIDTH-1:0] word_o
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [IW-1:0] IDX_TOP = IW'(WIDTH - 1);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);

  sar_state_e       state_q;
  logic [IW-1:0]    idx_q;
  logic [WIDTH-1:0] trial_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ALIGN;
          trial_q <= '0;
          busy_q  <= 1'b1;
        end
        ST_ALIGN: if (tick_i) begin
          state_q          <= ST_RUN;
          idx_q            <= IDX_TOP;
          trial_q[WIDTH-1] <= 1'b1;
        end
        ST_RUN: if (tick_i) begin
          trial_q[idx_q] <= cmp_i;
          if (idx_q == '0) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end else begin
            trial_q[idx_q - IDX_ONE] <= 1'b1;
            idx_q                    <= idx_q - IDX_ONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // last decision: bit 0 is taken straight from the comparator
  assign load_o  = (state_q == ST_RUN) && tick_i && (idx_q == '0);
  assign word_o  = {trial_q[WIDTH-1:1], cmp_i};
  assign trial_o = trial_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/sar_rd_port.sv
module sar_rd_port #(
  parameter int WIDTH  = 12,
  parameter int BUS_W  = 8,
  parameter int RD_GAP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             hi_byte_i,
  input  logic             busy_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             start_o,
  output logic [BUS_W-1:0] data_o,
  output logic             data_en_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int HI_W  = WIDTH - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;
  localparam int GW    = (RD_GAP > 0) ? $clog2(RD_GAP + 1) : 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(RD_GAP);

  logic             acc, acc_q;
  logic [GW-1:0]    gap_q;
  logic [WIDTH-1:0] lat_q;

  assign acc = sel_i & rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      gap_q <= GAP_MAX;
    end else begin
      acc_q <= acc;
      if (acc)                  gap_q <= '0;
      else if (gap_q < GAP_MAX) gap_q <= gap_q + GW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (load_i) lat_q <= word_i;
  end

  assign start_o   = acc & ~acc_q & ~hi_byte_i & ~busy_i & (gap_q >= GAP_MAX);
  assign data_en_o = acc;
  assign data_o    = hi_byte_i ? {{PAD_W{1'b0}}, lat_q[WIDTH-1:BUS_W]} : lat_q[BUS_W-1:0];
  assign result_o  = lat_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH   = 12,
  parameter int BUS_W   = 8,
  parameter int CLK_DIV = 2,
  parameter int RD_GAP  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             hi_byte_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic [BUS_W-1:0] data_o,
  output logic             data_en_o
);
  logic             tick, start, load;
  logic [WIDTH-1:0] word, result_w;

  sar_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tick_i (tick),
    .cmp_i  (cmp_i),
    .trial_o(trial_o),
    .busy_o (busy_o),
    .load_o (load),
    .word_o (word)
  );

  sar_rd_port #(.WIDTH(WIDTH), .BUS_W(BUS_W), .RD_GAP(RD_GAP)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .rd_i     (rd_i),
    .hi_byte_i(hi_byte_i),
    .busy_i   (busy_o),
    .load_i   (load),
    .word_i   (word),
    .start_o  (start),
    .data_o   (data_o),
    .data_en_o(data_en_o),
    .result_o (result_w)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 12,
  parameter int BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             rd_i,
  input logic             hi_byte_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] trial_o,
  input logic [BUS_W-1:0] data_o,
  input logic             data_en_o,
  input logic [WIDTH-1:0] result_w
);
  localparam int HI_W = WIDTH - BUS_W;

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(sel_i && rd_i && !hi_byte_i));

  assert_trial_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (trial_o == '0));

  assert_one_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($countones(trial_o ^ $past(trial_o)) <= 2));

  assert_latch_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (result_w[WIDTH-1:1] == $past(trial_o[WIDTH-1:1])));

  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(result_w));

  assert_hi_pad_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_o && hi_byte_i) |-> (data_o[BUS_W-1:HI_W] == '0));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH), .BUS_W(BUS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .rd_i     (rd_i),
  .hi_byte_i(hi_byte_i),
  .busy_o   (busy_o),
  .trial_o  (trial_o),
  .data_o   (data_o),
  .data_en_o(data_en_o),
  .result_w (result_w)
);

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
  localparam int W   = 12;
  localparam int BW  = 8;
  localparam int DIV = 2;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, hi = 1'b0;
  logic [W-1:0]  target = '0;
  logic [W-1:0]  trial;
  logic          busy, den, cmp;
  logic [BW-1:0] dat;

  int n_chk = 0, n_fail = 0;
  int edge_n = 0;
  int cyc = 0;
  int n_long = 0, n_short = 0;

  // reference model state
  logic         m_busy = 1'b0, m_prev = 1'b0;
  int           m_ticks = 0, m_idle = GAP;
  logic [W-1:0] m_res = '0;

  // observed busy edges
  logic o_busy = 1'b0;
  int   o_start = 0;

  always #5 clk = ~clk;
  assign cmp = (target >= trial);

  sar_conv_ctrl #(.WIDTH(W), .BUS_W(BW), .CLK_DIV(DIV), .RD_GAP(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .hi_byte_i(hi),
    .cmp_i(cmp), .trial_o(trial), .busy_o(busy), .data_o(dat), .data_en_o(den)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", tag, act, exp, edge_n);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_n = 0; m_busy = 1'b0; m_prev = 1'b0; m_ticks = 0; m_idle = GAP; m_res = '0;
    end else begin
      logic acc, go, tk;
      edge_n++;
      tk  = (edge_n % DIV) == 0;
      acc = sel & rd;
      go  = acc && !m_prev && !hi && !m_busy && (m_idle >= GAP);
      if (m_busy && tk) begin
        m_ticks++;
        if (m_ticks == W + 1) begin
          m_busy = 1'b0;
          m_res  = target;
        end
      end
      if (go) begin
        m_busy  = 1'b1;
        m_ticks = 0;
      end
      if (acc) m_idle = 0;
      else if (m_idle < GAP) m_idle++;
      m_prev = acc;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [BW-1:0] exp_d;
      exp_d = hi ? BW'(m_res[W-1:BW]) : m_res[BW-1:0];
      chk(busy == m_busy, "R2/R8/R10 busy", int'(busy), int'(m_busy));
      chk(den == (sel & rd), "R9 enable", int'(den), int'(sel & rd));
      if (den) chk(dat == exp_d, "R7/R9 bus data", int'(dat), int'(exp_d));
      if (busy && !o_busy) begin
        o_start = edge_n;
        chk(trial == '0, "R4 trial cleared", int'(trial), 0);
      end
      if (!busy && o_busy) begin
        int dur;
        dur = edge_n - o_start;
        chk(dur >= 12*DIV + 1 && dur <= 13*DIV, "R6 busy length", dur, 13*DIV);
        if (o_start % DIV == 0) begin
          n_long++;
          chk(dur == 13*DIV, "R6 aligned start", dur, 13*DIV);
        end else n_short++;
      end
      o_busy = busy;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  task automatic access(input logic h, input int len, input int gap);
    @(posedge clk); #2; sel = 1'b1; rd = 1'b1; hi = h;
    repeat (len) @(posedge clk);
    #2; sel = 1'b0; rd = 1'b0; hi = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic convert(input logic [W-1:0] t, input int phase);
    target = t;
    repeat (phase) @(posedge clk);
    access(1'b0, 1, GAP);
    wait_idle();
    access(1'b1, 1, GAP);  // upper bits visible on bus, checked by the model compare
    #1; chk(busy == 1'b0, "R3 high read no start", int'(busy), 0);
  endtask

  initial begin
    #23; 
    chk(busy == 1'b0 && trial == '0 && den == 1'b0, "R1 reset state", int'({busy, den}), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    access(1'b1, 1, GAP);
    #1; chk(dat == '0, "R1 latch zero", int'(dat), 0);

    // R5: fixed corner codes, then random, at varying prescaler phase
    convert(12'h000, 0);
    convert(12'hFFF, 1);
    convert(12'h800, 0);
    convert(12'h7FF, 1);
    convert(12'h555, 0);
    convert(12'hAAA, 1);
    for (int k = 0; k < 8; k++) convert(W'($urandom), k % DIV);

    // R8: a request in mid-conversion is ignored, latch keeps old value
    target = 12'h3C5;
    access(1'b0, 1, GAP + 2);
    target = 12'h3C5;
    access(1'b0, 1, 0);
    #1; chk(busy == 1'b1, "R8 still busy", int'(busy), 1);
    wait_idle();
    access(1'b1, 1, GAP);

    // R10: second access after a too-short gap is ignored
    access(1'b1, 1, 1);
    access(1'b0, 1, 0);
    #1; chk(busy == 1'b0, "R10 gap too short", int'(busy), 0);
    repeat (GAP + 2) @(posedge clk);

    // R2: access held open across the end of a conversion starts only once
    target = 12'h19E;
    access(1'b0, 15*DIV + 6, 0);
    #1; chk(busy == 1'b0, "R2 held access no restart", int'(busy), 0);
    repeat (GAP + 2) @(posedge clk);
    access(1'b1, 1, GAP);

    chk(n_long > 0 && n_short > 0, "R6 both phases hit", n_long, n_short);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule